// File: doc/BRIEF.md
# Linear CCD Line Readout Sequencer

This block produces the timing for a two-phase linear CCD. The CCD shifts out 2068 positions per line. The block runs from a master clock at four times the pixel rate. It drives the transfer gate, both horizontal phases, the summing gate, the reset gate and the anti-blooming gate. A line starts with a transfer-gate pulse of programmable width, with the first horizontal phase held high. The first phase then stays high for a programmable overlap after the transfer gate falls. After that the block clocks out the horizontal register one pixel per four master cycles.

For every position the block gives a one-cycle valid strobe with the position index, and a flag that marks the 2048 light-sensitive pixels apart from the dummy elements. The order of positions is:
- 16 leading dummies
- the active pixels
- 4 trailing dummies

If the programmed line period is longer than the readout, the horizontal, summing and reset clocks keep running with no strobes until the next transfer-gate pulse. This carries away dark charge from the register.

The transfer-gate width, overlap and line period are sampled once, at the start of each line. Each is clamped to its legal minimum.

Top module: `ccd_line_timer`

## Requirements
- R1: Each line produces exactly 2068 strobes with indexes 0,1,...,2067 in ascending order. The active flag is high for exactly the indexes 16 to 2063 (2048 strobes) and low for the rest.
- R2: The transfer gate stays high for max(tg_width_i, 32) master cycles at the start of each line.
- R3: The first phase is high for the whole transfer-gate pulse. It stays high for a further max(overlap_i, 16) cycles after the transfer gate falls, with the second phase low, before clocking starts.
- R4: During clocking the two phases are complementary. In each four-cycle pixel the first phase is high in cycles 0 and 1 and the second phase is high in cycles 2 and 3.
- R5: The summing gate equals the first phase while clocking and is low during the transfer pulse and the overlap.
- R6: The reset gate is high for exactly one master cycle per pixel, the cycle in which the first phase rises.
- R7: The valid strobe is high for one master cycle per output position, in pixel cycle 2, after the reset pulse.
- R8: The line period in master cycles is max(line_period_i, W + V + 8272). W and V are the clamped transfer width and overlap. In any time after the 2068th position, clocking continues as in R4 to R6 and no strobe is given.
- R9: The anti-blooming output equals shutter_i when shutter_en_i is 1 and is 0 otherwise, with one master cycle of latency.
- R10: While rst_ni is low all outputs are idle: transfer gate low, first phase high, and second phase, summing gate, reset gate, anti-blooming gate and strobe low. The transfer gate rises on the second master clock edge after reset is released.
- R11: Changes to tg_width_i, overlap_i or line_period_i in the middle of a line take effect only from the next line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, 4x pixel rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tg_width_i | input | 16 | Transfer-gate width in master cycles |
| overlap_i | input | 16 | First-phase hold after transfer-gate fall, master cycles |
| line_period_i | input | 20 | Line period in master cycles |
| shutter_en_i | input | 1 | Lets shutter_i drive the anti-blooming gate |
| shutter_i | input | 1 | Anti-blooming gate level when enabled |
| tg_o | output | 1 | Transfer gate |
| p1h_o | output | 1 | Horizontal phase 1 |
| p2h_o | output | 1 | Horizontal phase 2 |
| sg_o | output | 1 | Summing gate |
| rg_o | output | 1 | Reset gate |
| abg_o | output | 1 | Anti-blooming gate |
| pix_valid_o | output | 1 | One-cycle strobe per output position |
| pix_idx_o | output | 12 | Position index 0..2067 |
| pix_active_o | output | 1 | High for active (non-dummy) positions |

## Verification
The assertions check on every cycle the relationships between the outputs:
- The two phases are never both high or both low.
- The transfer gate and the summing gate only ever appear with the first phase high.
- The reset and strobe pulses last one cycle.
- The index steps by one.
- Flushing starts only after the readout has ended.
- Line time is bounded by the latched period.

Only the bench scenarios can show the things that need a count over a whole line against the programmed values:
- the exact transfer and overlap lengths after clamping;
- the line period, including the exact-minimum and below-minimum cases;
- the 2048 active flags out of 2068 strobes;
- the delayed effect of mid-line configuration changes;
- the restart point after a reset in the middle of a line.

// File: rtl/ccd_timing_pkg.sv
package ccd_timing_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TG,
    ST_OVL,
    ST_READ,
    ST_FLUSH
  } seq_st_e;
endpackage

// File: rtl/ccd_line_seq.sv
module ccd_line_seq
  import ccd_timing_pkg::*;
#(
  parameter int N_LEAD  = 16,
  parameter int N_ACT   = 2048,
  parameter int N_TRAIL = 4,
  parameter int CFG_W   = 16,
  parameter int PER_W   = 20,
  parameter int TG_MIN  = 32,
  parameter int OV_MIN  = 16,
  localparam int N_POS    = N_LEAD + N_ACT + N_TRAIL,
  localparam int IDX_W    = $clog2(N_POS),
  localparam int READ_CYC = 4 * N_POS
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] tg_width_i,
  input  logic [CFG_W-1:0] overlap_i,
  input  logic [PER_W-1:0] line_period_i,
  output seq_st_e          st_o,
  output logic [1:0]       sub_o,
  output logic [IDX_W-1:0] pix_o
);

  seq_st_e          st_q;
  logic [CFG_W-1:0] cyc_q, tgw_q, ovl_q;
  logic [PER_W-1:0] line_cnt_q, per_q;
  logic [1:0]       sub_q;
  logic [IDX_W-1:0] pix_q;

  logic [CFG_W-1:0] tgw_n, ovl_n;
  logic [PER_W-1:0] min_per, per_n;
  logic             last_cyc, end_read, start_line;

  // clamp configuration; only sampled at line start
  always_comb begin
    tgw_n   = (tg_width_i < CFG_W'(TG_MIN)) ? CFG_W'(TG_MIN) : tg_width_i;
    ovl_n   = (overlap_i < CFG_W'(OV_MIN)) ? CFG_W'(OV_MIN) : overlap_i;
    min_per = PER_W'(tgw_n) + PER_W'(ovl_n) + PER_W'(READ_CYC);
    per_n   = (line_period_i < min_per) ? min_per : line_period_i;
  end

  assign last_cyc   = (line_cnt_q == per_q - PER_W'(1));
  assign end_read   = (st_q == ST_READ) && (sub_q == 2'd3) && (pix_q == IDX_W'(N_POS - 1));
  assign start_line = (st_q == ST_IDLE) || (end_read && last_cyc) ||
                      ((st_q == ST_FLUSH) && last_cyc);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      cyc_q      <= '0;
      line_cnt_q <= '0;
      sub_q      <= '0;
      pix_q      <= '0;
      tgw_q      <= CFG_W'(TG_MIN);
      ovl_q      <= CFG_W'(OV_MIN);
      per_q      <= '0;
    end else begin
      line_cnt_q <= line_cnt_q + PER_W'(1);
      unique case (st_q)
        ST_TG: begin
          if (cyc_q == tgw_q - CFG_W'(1)) begin
            st_q  <= ST_OVL;
            cyc_q <= '0;
          end else begin
            cyc_q <= cyc_q + CFG_W'(1);
          end
        end
        ST_OVL: begin
          if (cyc_q == ovl_q - CFG_W'(1)) begin
            st_q  <= ST_READ;
            cyc_q <= '0;
            sub_q <= '0;
            pix_q <= '0;
          end else begin
            cyc_q <= cyc_q + CFG_W'(1);
          end
        end
        ST_READ: begin
          sub_q <= sub_q + 2'd1;
          if (sub_q == 2'd3) begin
            if (pix_q == IDX_W'(N_POS - 1)) st_q <= ST_FLUSH;
            else                           pix_q <= pix_q + IDX_W'(1);
          end
        end
        ST_FLUSH: sub_q <= sub_q + 2'd1;
        default: ;
      endcase
      // line start overrides the phase transitions above
      if (start_line) begin
        st_q       <= ST_TG;
        cyc_q      <= '0;
        line_cnt_q <= '0;
        sub_q      <= '0;
        tgw_q      <= tgw_n;
        ovl_q      <= ovl_n;
        per_q      <= per_n;
      end
    end
  end

  assign st_o  = st_q;
  assign sub_o = sub_q;
  assign pix_o = pix_q;

  // R2: overlap entered only after a full transfer-gate window
  a_r2_tg_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OVL && cyc_q == '0) |-> ($past(st_q) == ST_TG && $past(cyc_q) == tgw_q - CFG_W'(1)));
  // R3: overlap phase never runs past its window
  a_r3_ovl_len: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_OVL) |-> (cyc_q < ovl_q));
  // R1: index advances by one per pixel
  a_r1_pix_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_READ && sub_q == 2'd3 && pix_q != IDX_W'(N_POS - 1)) |=> (pix_q == $past(pix_q) + IDX_W'(1)));
  // R8: flushing only after the full readout
  a_r8_flush_late: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_FLUSH) |-> (line_cnt_q >= PER_W'(tgw_q) + PER_W'(ovl_q) + PER_W'(READ_CYC)));
  // R8: line never exceeds the latched period
  a_r8_per_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |-> (line_cnt_q < per_q));

endmodule

// File: rtl/ccd_clk_gen.sv
module ccd_clk_gen
  import ccd_timing_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  seq_st_e    st_i,
  input  logic [1:0] sub_i,
  input  logic       shutter_en_i,
  input  logic       shutter_i,
  output logic       tg_o,
  output logic       p1h_o,
  output logic       p2h_o,
  output logic       sg_o,
  output logic       rg_o,
  output logic       abg_o
);

  logic tg_d, p1_d, p2_d, sg_d, rg_d;

  always_comb begin
    tg_d = 1'b0;
    p1_d = 1'b1;
    p2_d = 1'b0;
    sg_d = 1'b0;
    rg_d = 1'b0;
    unique case (st_i)
      ST_TG: tg_d = 1'b1;
      ST_READ, ST_FLUSH: begin
        p1_d = ~sub_i[1];
        p2_d = sub_i[1];
        sg_d = ~sub_i[1];
        rg_d = (sub_i == 2'd0);
      end
      default: ;
    endcase
  end

  // registered so the pad drivers see glitch-free edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tg_o  <= 1'b0;
      p1h_o <= 1'b1;
      p2h_o <= 1'b0;
      sg_o  <= 1'b0;
      rg_o  <= 1'b0;
      abg_o <= 1'b0;
    end else begin
      tg_o  <= tg_d;
      p1h_o <= p1_d;
      p2h_o <= p2_d;
      sg_o  <= sg_d;
      rg_o  <= rg_d;
      abg_o <= shutter_en_i & shutter_i;
    end
  end

  a_r4_complement: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (p1h_o ^ p2h_o));
  a_r3_tg_under_p1h: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tg_o |-> p1h_o);
  a_r5_sg_with_p1h: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sg_o |-> (p1h_o && !tg_o));
  a_r6_rg_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rg_o |=> !rg_o);
  a_r6_rg_at_p1_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rg_o |=> p1h_o);

endmodule

// File: rtl/ccd_pix_tag.sv
module ccd_pix_tag
  import ccd_timing_pkg::*;
#(
  parameter int N_LEAD = 16,
  parameter int N_ACT  = 2048,
  parameter int IDX_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  seq_st_e          st_i,
  input  logic [1:0]       sub_i,
  input  logic [IDX_W-1:0] pix_i,
  output logic             pix_valid_o,
  output logic [IDX_W-1:0] pix_idx_o,
  output logic             pix_active_o
);

  logic valid_d, active_d;

  // strobe in pixel cycle 2, after reset pulse and during phase 2
  assign valid_d  = (st_i == ST_READ) && (sub_i == 2'd2);
  assign active_d = (pix_i >= IDX_W'(N_LEAD)) && (pix_i < IDX_W'(N_LEAD + N_ACT));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pix_valid_o  <= 1'b0;
      pix_idx_o    <= '0;
      pix_active_o <= 1'b0;
    end else begin
      pix_valid_o  <= valid_d;
      pix_idx_o    <= pix_i;
      pix_active_o <= valid_d & active_d;
    end
  end

  a_r7_strobe_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_valid_o |=> !pix_valid_o);
  a_r1_active_needs_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_active_o |-> pix_valid_o);

endmodule

// File: rtl/ccd_line_timer.sv
module ccd_line_timer
  import ccd_timing_pkg::*;
#(
  parameter int N_LEAD  = 16,
  parameter int N_ACT   = 2048,
  parameter int N_TRAIL = 4,
  parameter int CFG_W   = 16,
  parameter int PER_W   = 20,
  parameter int TG_MIN  = 32,
  parameter int OV_MIN  = 16,
  localparam int N_POS  = N_LEAD + N_ACT + N_TRAIL,
  localparam int IDX_W  = $clog2(N_POS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CFG_W-1:0] tg_width_i,
  input  logic [CFG_W-1:0] overlap_i,
  input  logic [PER_W-1:0] line_period_i,
  input  logic             shutter_en_i,
  input  logic             shutter_i,
  output logic             tg_o,
  output logic             p1h_o,
  output logic             p2h_o,
  output logic             sg_o,
  output logic             rg_o,
  output logic             abg_o,
  output logic             pix_valid_o,
  output logic [IDX_W-1:0] pix_idx_o,
  output logic             pix_active_o
);

  seq_st_e          st;
  logic [1:0]       sub;
  logic [IDX_W-1:0] pix;

  ccd_line_seq #(
    .N_LEAD(N_LEAD), .N_ACT(N_ACT), .N_TRAIL(N_TRAIL),
    .CFG_W(CFG_W), .PER_W(PER_W), .TG_MIN(TG_MIN), .OV_MIN(OV_MIN)
  ) u_seq (
    .clk_i, .rst_ni, .tg_width_i, .overlap_i, .line_period_i,
    .st_o(st), .sub_o(sub), .pix_o(pix)
  );

  ccd_clk_gen u_clk (
    .clk_i, .rst_ni, .st_i(st), .sub_i(sub),
    .shutter_en_i, .shutter_i,
    .tg_o, .p1h_o, .p2h_o, .sg_o, .rg_o, .abg_o
  );

  ccd_pix_tag #(.N_LEAD(N_LEAD), .N_ACT(N_ACT), .IDX_W(IDX_W)) u_tag (
    .clk_i, .rst_ni, .st_i(st), .sub_i(sub), .pix_i(pix),
    .pix_valid_o, .pix_idx_o, .pix_active_o
  );

endmodule

// File: tb/ccd_line_timer_tb_top.sv
module ccd_line_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N_POS      = 2068;
  localparam int READ_CYC   = 4 * N_POS;
  localparam int TG_MIN     = 32;
  localparam int OV_MIN     = 16;
  localparam int N_LINES    = 11;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] tg_width_i = '0, overlap_i = '0;
  logic [19:0] line_period_i = '0;
  logic        shutter_en_i = 1'b0, shutter_i = 1'b0;
  logic        tg_o, p1h_o, p2h_o, sg_o, rg_o, abg_o, pix_valid_o, pix_active_o;
  logic [11:0] pix_idx_o;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  ccd_line_timer dut_i (
    .clk_i(clk), .rst_ni, .tg_width_i, .overlap_i, .line_period_i,
    .shutter_en_i, .shutter_i, .tg_o, .p1h_o, .p2h_o, .sg_o, .rg_o, .abg_o,
    .pix_valid_o, .pix_idx_o, .pix_active_o
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      if (errors < 25) $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic report;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic int clampi(input int v, input int m);
    return (v < m) ? m : v;
  endfunction

  task automatic set_cfg(input int i);
    int tw, ov, mn;
    case (i)
      0: begin tw = 0; ov = 0; line_period_i = 20'd0; end             // all clamped
      1: begin tw = 200; ov = 100; line_period_i = 20'(200 + 100 + READ_CYC); end // exact minimum
      2: begin tw = 50; ov = 20; line_period_i = 20'(50 + 20 + READ_CYC - 1); end // one below
      3: begin tw = TG_MIN - 1; ov = OV_MIN; line_period_i = 20'(TG_MIN + OV_MIN + READ_CYC + 1500); end
      default: begin
        tw = $urandom_range(0, 150);
        ov = $urandom_range(0, 90);
        mn = clampi(tw, TG_MIN) + clampi(ov, OV_MIN) + READ_CYC;
        if ($urandom_range(0, 3) == 0) line_period_i = 20'($urandom_range(0, 9000));
        else                           line_period_i = 20'(mn + $urandom_range(0, 2500));
      end
    endcase
    tg_width_i = 16'(tw);
    overlap_i  = 16'(ov);
  endtask

  task automatic chk_idle(input string tag);
    chk(tg_o == 1'b0, tag, "tg idle", tg_o, 0);
    chk(p1h_o == 1'b1, tag, "p1h idle", p1h_o, 1);
    chk(p2h_o == 1'b0, tag, "p2h idle", p2h_o, 0);
    chk(sg_o == 1'b0, tag, "sg idle", sg_o, 0);
    chk(rg_o == 1'b0, tag, "rg idle", rg_o, 0);
    chk(abg_o == 1'b0, tag, "abg idle", abg_o, 0);
    chk(pix_valid_o == 1'b0, tag, "strobe idle", pix_valid_o, 0);
  endtask

  initial begin
    #(longint'(CLK_PERIOD) * 190000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      report();
    end
  end

  initial begin
    int k, tgw_m, ov_m, per_m, line_no, strobes, actives, rel_cnt, r, sb, idx;
    bit synced, tracking, prev_en, prev_sh, did_reset;
    bit e_tg, e_p1, e_p2, e_sg, e_rg, e_v, inclk;
    void'($urandom(32'd20250611));
    k = 0; tgw_m = 0; ov_m = 0; per_m = 1; line_no = 0; strobes = 0; actives = 0;
    rel_cnt = 0; synced = 0; tracking = 0; did_reset = 0;
    set_cfg(0);
    prev_en = 1'b1; prev_sh = 1'b1;
    shutter_en_i = prev_en; shutter_i = prev_sh;
    repeat (3) @(negedge clk);
    chk_idle("R10");                 // reset state, shutter inputs high but gated by reset
    rst_ni = 1'b1;
    tracking = 1;

    while (line_no < N_LINES) begin
      @(negedge clk);
      // R9: anti-blooming follows gated shutter one cycle late
      chk(abg_o == (prev_en & prev_sh), "R9", "abg", abg_o, prev_en & prev_sh);
      prev_en = 1'($urandom_range(0, 1));
      prev_sh = 1'($urandom_range(0, 1));
      shutter_en_i = prev_en;
      shutter_i    = prev_sh;

      if (tracking) begin
        rel_cnt++;
        if (tg_o) begin
          chk(rel_cnt == 2, "R10", "tg rise after release", rel_cnt, 2);
          tracking = 0;
        end else if (rel_cnt > 2) begin
          chk(1'b0, "R10", "tg late after release", rel_cnt, 2);
          tracking = 0;
        end
      end

      if (!synced && tg_o) begin
        synced = 1; k = 0; strobes = 0; actives = 0;
      end
      if (!synced) continue;

      if (k == 0) begin
        tgw_m = clampi(int'(tg_width_i), TG_MIN);
        ov_m  = clampi(int'(overlap_i), OV_MIN);
        per_m = (int'(line_period_i) < tgw_m + ov_m + READ_CYC) ?
                tgw_m + ov_m + READ_CYC : int'(line_period_i);
      end

      r     = k - tgw_m - ov_m;
      inclk = (r >= 0);
      sb    = inclk ? (r % 4) : 0;
      idx   = inclk ? (r / 4) : 0;
      e_tg  = (k < tgw_m);
      e_p1  = !inclk || (sb < 2);
      e_p2  = inclk && (sb >= 2);
      e_sg  = inclk && (sb < 2);
      e_rg  = inclk && (sb == 0);
      e_v   = inclk && (r < READ_CYC) && (sb == 2);

      chk(tg_o == e_tg, (k == 0) ? "R8 R11" : "R2", "tg", tg_o, e_tg);
      chk(p1h_o == e_p1, inclk ? "R4" : "R3", "p1h", p1h_o, e_p1);
      chk(p2h_o == e_p2, inclk ? "R4" : "R3", "p2h", p2h_o, e_p2);
      chk(sg_o == e_sg, "R5", "sg", sg_o, e_sg);
      chk(rg_o == e_rg, "R6", "rg", rg_o, e_rg);
      chk(pix_valid_o == e_v, (r >= READ_CYC) ? "R8" : "R7", "strobe", pix_valid_o, e_v);
      if (e_v) begin
        chk(int'(pix_idx_o) == idx, "R1", "index", pix_idx_o, idx);
        chk(pix_active_o == (idx >= 16 && idx < 2064), "R1", "active flag",
            pix_active_o, (idx >= 16 && idx < 2064));
      end
      if (pix_valid_o) strobes++;
      if (pix_valid_o && pix_active_o) actives++;

      // R11: new settings mid-readout must only apply to the next line
      if (k == tgw_m + ov_m + 50) set_cfg(line_no + 1);

      if (line_no == 5 && !did_reset && k == tgw_m + ov_m + 4000) begin
        did_reset = 1;
        rst_ni = 1'b0;
        #1;
        chk_idle("R10");
        repeat (3) @(negedge clk);
        prev_en = 1'b0; prev_sh = 1'b0;
        shutter_en_i = 1'b0; shutter_i = 1'b0;
        rst_ni = 1'b1;
        synced = 0; tracking = 1; rel_cnt = 0;
        continue;
      end

      k++;
      if (k == per_m) begin
        chk(strobes == N_POS, "R1", "strobes per line", strobes, N_POS);
        chk(actives == 2048, "R1", "active per line", actives, 2048);
        line_no++;
        k = 0; strobes = 0; actives = 0;
      end
    end
    done = 1;
    report();
  end
endmodule